// File: doc/BRIEF.md
# Time-Multiplexed Four-Digit Seven-Segment Scanner

This block lights a four-digit, common-anode seven-segment display from four hexadecimal nibbles and four decimal-point flags. The seven segment lines and the point line are one bus shared by every digit. The block therefore turns on one digit at a time and puts that digit's glyph on the shared bus. It steps to the next digit at a fixed rate, so the eye sees all four digits as steadily lit.

A prescaler, derived from the clock frequency, sets how long each digit stays on. A small index counter selects the active digit. The selected nibble passes through a hexadecimal glyph decoder. The enable lines and the cathode lines are registered together in one output stage, so they always change on the same clock edge. Every output is active low, which matches a display whose anode enables are driven through inverting transistors.

With the default parameters (100 MHz clock, 1 kHz per-digit rate) each digit stays on for 1 ms. A full scan takes 4 ms, which is inside the 1 ms to 16 ms window that keeps the display free of flicker.

Top module: `seg_scan_top`

## Requirements
- R1: All outputs are active low. A digit is on when its `digit_en_n` bit is 0, and a segment or the point is lit when its line is 0.
- R2: From the first clock edge after reset is released, exactly one bit of `digit_en_n` is 0 at every moment.
- R3: Each digit stays enabled for exactly CLK_HZ/SCAN_DIGIT_HZ consecutive clock cycles, so a full scan lasts four times that. The defaults give 1 ms per digit and a 4 ms scan.
- R4: Digit i drives `digit_en_n[i]` and shows nibble `hex_digits[4i+3:4i]`. The scan order is 0, 1, 2, 3 and then repeats. Digit 0 is always the first digit after reset.
- R5: The cathode bus always carries the glyph of the digit whose enable is low. Enable and cathodes change on the same edge. A change on `hex_digits` or `dp_flags` appears on the outputs one clock edge later.
- R6: `seg_n[6:0]` is ordered G,F,E,D,C,B,A (bit 6 = G, bit 0 = A). It decodes 0=1000000, 1=1111001 (only B and C low), 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000010, 7=1111000, 8=0000000, 9=0010000, A=0001000.
- R7: The remaining hexadecimal values decode as b=0000011, C=1000110, d=0100001, E=0000110, F=0001110 (same bit order as R6).
- R8: `dp_n` equals the inverse of `dp_flags[i]` for the active digit i.
- R9: At every clock edge where `rst` is high, all enables, all segments and the point are driven high, so the display is dark. After reset the scan restarts at digit 0 with a full dwell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hex_digits | input | 16 | Four nibbles; nibble i is shown on digit i |
| dp_flags | input | 4 | Decimal-point request per digit, active high |
| digit_en_n | output | 4 | Digit enables, active low, one hot |
| seg_n | output | 7 | Shared segment cathodes G..A, active low |
| dp_n | output | 1 | Shared decimal-point cathode, active low |

## Verification
All outputs come from a single register stage. A new nibble or point flag therefore appears on the cathodes one clock edge after it is applied, and not before that edge. A digit switch appears on the enables and the cathodes at the same edge. The bench drives its inputs on falling edges and samples the outputs on the next falling edge. It also checks the value held 1 ns after the input change, which proves the one-edge latency. Dwell is measured by counting falling-edge samples during which an enable pattern holds. That count must equal CLK_HZ/SCAN_DIGIT_HZ, set to 8 in the bench so that every digit boundary can be observed.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

    localparam int NIBBLE_W  = 4;
    localparam int SEG_COUNT = 7;

    typedef logic [NIBBLE_W-1:0]  nibble_t;
    typedef logic [SEG_COUNT-1:0] seg_bits_t;

    // One shared cathode bus word: point plus seven segments, all active low.
    typedef struct packed {
        logic      dp_n;
        seg_bits_t seg_n;
    } cathode_t;

    localparam cathode_t CATHODE_DARK = '{dp_n: 1'b1, seg_n: '1};

    // Prescaler terminal count, never below two so the counter is real logic.
    function automatic int dwell_cycles(input int clk_hz, input int digit_hz);
        int q;
        q = clk_hz / digit_hz;
        return (q < 2) ? 2 : q;
    endfunction

    // Hex glyph, bit 6 = G down to bit 0 = A, a zero lights the segment.
    function automatic seg_bits_t glyph_low(input nibble_t v);
        seg_bits_t g;
        unique case (v)
            4'h0: g = 7'b1000000;
            4'h1: g = 7'b1111001;
            4'h2: g = 7'b0100100;
            4'h3: g = 7'b0110000;
            4'h4: g = 7'b0011001;
            4'h5: g = 7'b0010010;
            4'h6: g = 7'b0000010;
            4'h7: g = 7'b1111000;
            4'h8: g = 7'b0000000;
            4'h9: g = 7'b0010000;
            4'hA: g = 7'b0001000;
            4'hB: g = 7'b0000011;
            4'hC: g = 7'b1000110;
            4'hD: g = 7'b0100001;
            4'hE: g = 7'b0000110;
            default: g = 7'b0001110;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/seg_scan_prescaler.sv
module seg_scan_prescaler #(
    parameter int TICK_CNT = 100000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_CNT > 1) ? $clog2(TICK_CNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CNT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/seg_scan_digit_sel.sv
module seg_scan_digit_sel #(
    parameter int NUM_DIGITS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick,
    output logic [$clog2(NUM_DIGITS)-1:0] idx,
    output logic [NUM_DIGITS-1:0]         sel_oh
);
    localparam int IDX_W = $clog2(NUM_DIGITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (tick) begin
            idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_sel
        assign sel_oh[g] = (idx == IDX_W'(g));
    end
endmodule

// File: rtl/seg_scan_decoder.sv
module seg_scan_decoder
    import seg_scan_pkg::*;
(
    input  nibble_t  nib,
    input  logic     dp_req,
    output cathode_t cath
);
    always_comb begin
        cath.seg_n = glyph_low(nib);
        cath.dp_n  = ~dp_req;
    end
endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top
    import seg_scan_pkg::*;
#(
    parameter int CLK_HZ        = 100_000_000,
    parameter int SCAN_DIGIT_HZ = 1000,
    parameter int NUM_DIGITS    = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_DIGITS*NIBBLE_W-1:0] hex_digits,
    input  logic [NUM_DIGITS-1:0]          dp_flags,
    output logic [NUM_DIGITS-1:0]          digit_en_n,
    output logic [SEG_COUNT-1:0]           seg_n,
    output logic                           dp_n
);
    localparam int TICK_CNT = dwell_cycles(CLK_HZ, SCAN_DIGIT_HZ);
    localparam int IDX_W    = $clog2(NUM_DIGITS);

    logic                  tick;
    logic [IDX_W-1:0]      idx;
    logic [NUM_DIGITS-1:0] sel_oh;
    nibble_t               cur_nib;
    logic                  cur_dp;
    cathode_t              next_cath;
    cathode_t              cath_q;
    logic [NUM_DIGITS-1:0] en_n_q;

    seg_scan_prescaler #(.TICK_CNT(TICK_CNT)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    seg_scan_digit_sel #(.NUM_DIGITS(NUM_DIGITS)) u_sel (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .idx    (idx),
        .sel_oh (sel_oh)
    );

    assign cur_nib = hex_digits[idx*NIBBLE_W +: NIBBLE_W];
    assign cur_dp  = dp_flags[idx];

    seg_scan_decoder u_dec (
        .nib    (cur_nib),
        .dp_req (cur_dp),
        .cath   (next_cath)
    );

    // Single output stage keeps enables and cathodes aligned to the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_n_q <= '1;
            cath_q <= CATHODE_DARK;
        end else begin
            en_n_q <= ~sel_oh;
            cath_q <= next_cath;
        end
    end

    assign digit_en_n = en_n_q;
    assign seg_n      = cath_q.seg_n;
    assign dp_n       = cath_q.dp_n;
endmodule

// File: rtl/seg_scan_checker.sv
module seg_scan_checker #(
    parameter int NUM_DIGITS = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_DIGITS*4-1:0] hex_digits,
    input logic [NUM_DIGITS-1:0]   dp_flags,
    input logic [NUM_DIGITS-1:0]   digit_en_n,
    input logic [6:0]              seg_n,
    input logic                    dp_n
);
    logic [NUM_DIGITS-1:0] en_prev;

    always_ff @(posedge clk) begin
        if (rst) en_prev <= '1;
        else     en_prev <= digit_en_n;
    end

    // R9: one edge after a reset edge everything is dark
    a_r9_dark_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (digit_en_n == '1 && seg_n == '1 && dp_n == 1'b1));

    // R2: exactly one digit on once out of reset
    a_r2_single_enable: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(~digit_en_n) == 1));

    // R4: a digit change moves to the next digit
    a_r4_scan_order: assert property (@(posedge clk) disable iff (rst)
        (digit_en_n != en_prev && en_prev != '1) |->
        (digit_en_n == {en_prev[NUM_DIGITS-2:0], en_prev[NUM_DIGITS-1]}));

    // R5: held inputs and a held digit keep the cathode bus steady
    a_r5_cathode_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $stable(digit_en_n) &&
         $past(hex_digits) == $past(hex_digits, 2) &&
         $past(dp_flags) == $past(dp_flags, 2)) |->
        ($stable(seg_n) && $stable(dp_n)));
endmodule

bind seg_scan_top seg_scan_checker #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hex_digits (hex_digits),
    .dp_flags   (dp_flags),
    .digit_en_n (digit_en_n),
    .seg_n      (seg_n),
    .dp_n       (dp_n)
);

// File: tb/seg_scan_top_test.sv
module seg_scan_top_test;
    localparam int DWELL = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] hex_digits = 16'h0000;
    logic [3:0]  dp_flags = 4'h0;
    logic [3:0]  digit_en_n;
    logic [6:0]  seg_n;
    logic        dp_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // {nibble, expected G..A glyph}
    localparam logic [10:0] VEC [16] = '{
        {4'h0, 7'b1000000}, {4'h1, 7'b1111001}, {4'h2, 7'b0100100},
        {4'h3, 7'b0110000}, {4'h4, 7'b0011001}, {4'h5, 7'b0010010},
        {4'h6, 7'b0000010}, {4'h7, 7'b1111000}, {4'h8, 7'b0000000},
        {4'h9, 7'b0010000}, {4'hA, 7'b0001000}, {4'hB, 7'b0000011},
        {4'hC, 7'b1000110}, {4'hD, 7'b0100001}, {4'hE, 7'b0000110},
        {4'hF, 7'b0001110}
    };

    seg_scan_top #(.CLK_HZ(8000), .SCAN_DIGIT_HZ(1000), .NUM_DIGITS(4)) uut (
        .clk        (clk),
        .rst        (rst),
        .hex_digits (hex_digits),
        .dp_flags   (dp_flags),
        .digit_en_n (digit_en_n),
        .seg_n      (seg_n),
        .dp_n       (dp_n)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_digit(input int k);
        for (int n = 0; n < 64; n++) begin
            if (digit_en_n == ~(4'b1 << k)) return;
            @(negedge clk);
        end
    endtask

    task automatic dwell_from_now(input string req);
        logic [3:0] cur;
        int n;
        cur = digit_en_n;
        n = 1;
        @(negedge clk);
        while (digit_en_n == cur && n < 100) begin
            n++;
            @(negedge clk);
        end
        check(n == DWELL, req, n, DWELL);
    endtask

    function automatic logic [6:0] glyph(input logic [3:0] v);
        return VEC[v][6:0];
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] exp_en;
        repeat (3) @(negedge clk);
        // R9 / R1: dark while in reset
        check(digit_en_n == 4'hF, "R9 reset enables", digit_en_n, 4'hF);
        check(seg_n == 7'h7F && dp_n, "R1 reset cathodes", {dp_n, seg_n}, 8'hFF);

        hex_digits = 16'h3A71;
        dp_flags   = 4'b0101;
        rst = 1'b0;
        @(negedge clk);
        check(digit_en_n == 4'b1110, "R4 first digit is 0", digit_en_n, 4'b1110);
        exp_en = 4'b1110;
        for (int i = 0; i < 4; i++) begin
            dwell_from_now("R3 dwell length");
            exp_en = {exp_en[2:0], exp_en[3]};
            check(digit_en_n == exp_en, "R4 scan order", digit_en_n, exp_en);
            check($countones(~digit_en_n) == 1, "R2 one enable", digit_en_n, exp_en);
        end

        // R5 / R8: bus follows the active digit
        for (int k = 0; k < 4; k++) begin
            logic [3:0] nib;
            wait_digit(k);
            nib = hex_digits[k*4 +: 4];
            check(seg_n == glyph(nib), "R5 glyph of active digit", seg_n, glyph(nib));
            check(dp_n == ~dp_flags[k], "R8 point of active digit", dp_n, ~dp_flags[k]);
        end

        // R6 / R7 / R5 latency: decode table, all digits the same value
        for (int i = 0; i < 16; i++) begin
            logic [6:0] prev;
            prev = seg_n;
            hex_digits = {4{VEC[i][10:7]}};
            dp_flags   = {4{VEC[i][7]}};
            #1;
            if (i > 0)
                check(seg_n == prev, "R5 no change before edge", seg_n, prev);
            @(negedge clk);
            check(seg_n == VEC[i][6:0], (i < 11) ? "R6 decode" : "R7 decode",
                  seg_n, VEC[i][6:0]);
            check(dp_n == ~VEC[i][7], "R8 point follows flag", dp_n, ~VEC[i][7]);
        end

        // R9: reset in the middle of a scan
        hex_digits = 16'h3A71;
        @(negedge clk);
        wait_digit(2);
        rst = 1'b1;
        @(negedge clk);
        check(digit_en_n == 4'hF, "R9 mid-scan reset dark", digit_en_n, 4'hF);
        check(seg_n == 7'h7F && dp_n, "R9 mid-scan cathodes dark", {dp_n, seg_n}, 8'hFF);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(digit_en_n == 4'b1110, "R9 restart at digit 0", digit_en_n, 4'b1110);
        check(seg_n == 7'b1111001, "R6 digit 0 shows 1 after restart", seg_n, 7'b1111001);
        dwell_from_now("R9 full first dwell");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule